// File: doc/BRIEF.md
# Bus-Master Channel Control Register File

This block holds the software-visible control state of one bus-master DMA channel of a disk controller. A host bus adapter issues byte, halfword or word accesses into an eight-byte window. The window holds a command byte, a status byte and a 32-bit pointer to a descriptor table in memory. The block turns command writes into a single start pulse and a base address for a separate descriptor-walking engine. It also keeps the "transfer active" bit that the engine clears when it finishes.

The channel's interrupt line from the drive side passes straight through to the downstream interrupt. Each low-to-high change of that line also sets a pending flag in the status byte, which software clears by writing a one to it. The active and pending bits can be read together.

Stopping a transfer cannot abort one that is already running. Clearing the start bit only records the new command value, and the active bit stays set until the engine reports completion. The pointer is always kept 4-byte aligned, whatever the access width.

Top module: `bmide_regfile`

## Requirements
- R1: After reset the command byte, status byte and table pointer read as zero, `dma_active` and `dma_start` are low, and a word read at offset 0 returns 0xFF00FF00.
- R2: A write to offset 0 stores only bits 0 (start) and 3 (direction) of the written byte, and the stored bit 3 appears on `xfer_dir`.
- R3: A command write that changes the start bit from 0 to 1 while `dma_active` is low sets `dma_active` and raises `dma_start` for exactly one cycle, starting the cycle after the write.
- R4: A command write that leaves the start bit at its stored value issues no start and leaves `dma_active` unchanged; the masked value is still stored.
- R5: A command write that changes the start bit from 1 to 0 leaves `dma_active` set until `xfer_done` is seen.
- R6: A 0-to-1 start change while `dma_active` is already high issues no `dma_start` pulse.
- R7: `xfer_done` high in a cycle clears `dma_active` at the next edge, and `xfer_err` sets status bit 1.
- R8: A write to the status byte (offset 2) loads bits 5 and 6 from the data, leaves bit 0 (active) unchanged, and clears bits 1 and 2 where the data has a one; bits 3, 4 and 7 read as zero.
- R9: A low-to-high change on `chan_irq_in` sets status bit 2 one edge later; if a write clearing bit 2 lands in the same cycle, the set wins.
- R10: `irq_out` follows `chan_irq_in` without delay on both edges, and a falling `chan_irq_in` leaves the status byte unchanged.
- R11: Writes of any width into offsets 4 to 7 replace only the addressed pointer bytes, and pointer bits 1:0 always read as zero on `tbl_base` and on reads.
- R12: Offsets 1 and 3 read as 0xFF, and writes to them change no state.
- R13: `acc_size` selects 1 byte (0), 2 bytes (1) or 4 bytes (2 or 3). An access covers consecutive offsets from `acc_addr` and is cut off at the end of its aligned 4-byte group. Read data is right-aligned, with uncovered bytes as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_wr | input | 1 | Write strobe for the register window |
| acc_addr | input | 3 | Byte offset of the access in the window |
| acc_size | input | 2 | Access width code: 0 byte, 1 halfword, 2 or 3 word |
| acc_wdata | input | 32 | Write data, right-aligned to the addressed offset |
| acc_rdata | output | 32 | Combinational read data, right-aligned |
| xfer_done | input | 1 | Engine reports that the running transfer has finished |
| xfer_err | input | 1 | Engine reports a transfer error |
| chan_irq_in | input | 1 | Interrupt request from the channel |
| irq_out | output | 1 | Interrupt request passed downstream |
| tbl_base | output | 32 | Descriptor table base, 4-byte aligned |
| dma_start | output | 1 | One-cycle start request to the engine |
| dma_active | output | 1 | Transfer-active status bit |
| xfer_dir | output | 1 | Stored direction bit of the command byte |

## Verification
The properties assume that `chan_irq_in` and `xfer_done` are synchronous to `clk` and are looked at only at rising edges. They also assume the engine raises `xfer_done` only to end a transfer it was started for. The stimulus changes every input on the falling clock edge. It pulses `xfer_done` only while a transfer is active, and it moves `chan_irq_in` one level at a time, so no edge of the interrupt is shorter than a clock period. Reads are made combinationally between edges with no write strobe, so reading never changes state.

// File: rtl/bmide_pkg.sv
package bmide_pkg;

  // access width codes
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // byte offsets inside the lower register group
  localparam int unsigned OFS_CMD    = 0;
  localparam int unsigned OFS_FILL_A = 1;
  localparam int unsigned OFS_STAT   = 2;
  localparam int unsigned OFS_FILL_B = 3;

  localparam logic [7:0] FILL_BYTE = 8'hFF;

  // command byte fields
  localparam int unsigned CMD_GO_BIT  = 0;
  localparam int unsigned CMD_DIR_BIT = 3;
  localparam logic [7:0]  CMD_KEEP    = 8'h09;

  // status byte fields
  localparam int unsigned ST_ACT_BIT = 0;
  localparam int unsigned ST_ERR_BIT = 1;
  localparam int unsigned ST_IRQ_BIT = 2;
  localparam logic [7:0]  ST_RW_MASK = 8'h60;
  localparam logic [7:0]  ST_ERR_MSK = 8'h02;
  localparam logic [7:0]  ST_IRQ_MSK = 8'h04;

endpackage

// File: rtl/bmide_rst_sync.sv
module bmide_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/bmide_lane_dec.sv
module bmide_lane_dec
  import bmide_pkg::*;
#(
  parameter int unsigned WIN_BYTES  = 8,
  parameter int unsigned DATA_BYTES = 4,
  parameter int unsigned AW         = $clog2(WIN_BYTES),
  parameter int unsigned GW         = $clog2(DATA_BYTES)
) (
  input  logic                    acc_wr,
  input  logic [AW-1:0]           acc_addr,
  input  logic [1:0]              acc_size,
  input  logic [8*DATA_BYTES-1:0] acc_wdata,
  input  logic [8*WIN_BYTES-1:0]  win_flat,
  output logic [WIN_BYTES-1:0]    wr_be,
  output logic [8*WIN_BYTES-1:0]  wr_bytes,
  output logic [8*DATA_BYTES-1:0] acc_rdata
);

  logic [GW:0]    nbytes;
  logic [GW-1:0]  off;
  logic [AW-GW-1:0] grp;

  always_comb begin
    case (acc_size)
      SZ_BYTE: nbytes = (GW+1)'(1);
      SZ_HALF: nbytes = (GW+1)'(2);
      default: nbytes = (GW+1)'(DATA_BYTES);
    endcase
  end

  assign off = acc_addr[GW-1:0];
  assign grp = acc_addr[AW-1:GW];

  // write lanes: one per window byte
  for (genvar i = 0; i < WIN_BYTES; i++) begin : g_wlane
    localparam logic [AW-1:0] IDX = AW'(i);
    logic [GW-1:0] rel;
    logic          hit;
    always_comb begin
      rel = IDX[GW-1:0] - off;
      hit = (IDX[AW-1:GW] == grp) && (IDX[GW-1:0] >= off) && ({1'b0, rel} < nbytes);
      wr_be[i] = acc_wr && hit;
      wr_bytes[8*i +: 8] = acc_wdata[8*rel +: 8];
    end
  end

  // read lanes: one per data byte, right-aligned
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_rlane
    logic [GW:0]   pos;
    logic [AW-1:0] src;
    logic          valid;
    always_comb begin
      pos   = {1'b0, off} + (GW+1)'(k);
      valid = ((GW+1)'(k) < nbytes) && !pos[GW];
      src   = {grp, pos[GW-1:0]};
      acc_rdata[8*k +: 8] = valid ? win_flat[8*src +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/bmide_cmd_ctl.sv
module bmide_cmd_ctl
  import bmide_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_wbyte,
  input  logic       xfer_done,
  output logic [7:0] cmd_q,
  output logic       dma_active,
  output logic       dma_start
);

  logic [7:0] cmd_d;
  logic       cmd_en;
  logic       go_rise;
  logic       act_q, act_d;
  logic       start_q, start_d;

  // next state
  always_comb begin
    cmd_en  = cmd_we;
    cmd_d   = cmd_wbyte & CMD_KEEP;
    go_rise = cmd_we && cmd_wbyte[CMD_GO_BIT] && !cmd_q[CMD_GO_BIT];
    start_d = go_rise && !act_q;
    if (start_d) begin
      act_d = 1'b1;
    end else if (xfer_done) begin
      act_d = 1'b0;
    end else begin
      act_d = act_q;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 8'h00;
      act_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (cmd_en) begin
        cmd_q <= cmd_d;
      end
      act_q   <= act_d;
      start_q <= start_d;
    end
  end

  assign dma_active = act_q;
  assign dma_start  = start_q;

endmodule

// File: rtl/bmide_stat_reg.sv
module bmide_stat_reg
  import bmide_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_we,
  input  logic [7:0] st_wbyte,
  input  logic       dma_active,
  input  logic       xfer_err,
  input  logic       chan_irq_in,
  output logic [7:0] stat_byte,
  output logic       irq_pend,
  output logic       irq_out
);

  logic [7:0] rw_q, rw_d;
  logic       rw_en;
  logic       err_q, err_d;
  logic       pend_q, pend_d;
  logic       irq_prev_q;
  logic       irq_rise;
  logic       clr_err, clr_pend;

  // next state: events set, one-writes clear, set wins
  always_comb begin
    rw_en    = st_we;
    rw_d     = st_wbyte & ST_RW_MASK;
    clr_err  = st_we && (|(st_wbyte & ST_ERR_MSK));
    clr_pend = st_we && (|(st_wbyte & ST_IRQ_MSK));
    irq_rise = chan_irq_in && !irq_prev_q;
    err_d    = xfer_err || (err_q && !clr_err);
    pend_d   = irq_rise || (pend_q && !clr_pend);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q       <= 8'h00;
      err_q      <= 1'b0;
      pend_q     <= 1'b0;
      irq_prev_q <= 1'b0;
    end else begin
      if (rw_en) begin
        rw_q <= rw_d;
      end
      err_q      <= err_d;
      pend_q     <= pend_d;
      irq_prev_q <= chan_irq_in;
    end
  end

  always_comb begin
    stat_byte             = rw_q;
    stat_byte[ST_ACT_BIT] = dma_active;
    stat_byte[ST_ERR_BIT] = err_q;
    stat_byte[ST_IRQ_BIT] = pend_q;
  end

  assign irq_pend = pend_q;
  assign irq_out  = chan_irq_in;

endmodule

// File: rtl/bmide_ptr_reg.sv
module bmide_ptr_reg #(
  parameter int unsigned PTR_BYTES  = 4,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PTR_BYTES-1:0]   ptr_be,
  input  logic [8*PTR_BYTES-1:0] ptr_wbytes,
  output logic [8*PTR_BYTES-1:0] ptr_q
);

  localparam logic [7:0] LOW_MASK = ~8'((1 << ALIGN_BITS) - 1);

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_pbyte
    logic [7:0] byte_q, byte_d;
    logic       byte_en;
    always_comb begin
      byte_en = ptr_be[b];
      if (b == 0) begin
        byte_d = ptr_wbytes[8*b +: 8] & LOW_MASK;
      end else begin
        byte_d = ptr_wbytes[8*b +: 8];
      end
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= 8'h00;
      end else if (byte_en) begin
        byte_q <= byte_d;
      end
    end
    assign ptr_q[8*b +: 8] = byte_q;
  end

endmodule

// File: rtl/bmide_regfile.sv
module bmide_regfile
  import bmide_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic              xfer_done,
  input  logic              xfer_err,
  input  logic              chan_irq_in,
  output logic              irq_out,
  output logic [DATA_W-1:0] tbl_base,
  output logic              dma_start,
  output logic              dma_active,
  output logic              xfer_dir
);

  localparam int unsigned DATA_BYTES = DATA_W / 8;
  localparam int unsigned WIN_BYTES  = 2 * DATA_BYTES;

  logic                   rst_sync_n;
  logic [WIN_BYTES-1:0]   wr_be;
  logic [8*WIN_BYTES-1:0] wr_bytes;
  logic [8*WIN_BYTES-1:0] win_flat;
  logic [7:0]             cmd_q;
  logic [7:0]             stat_byte;
  logic                   irq_pend;
  logic [DATA_W-1:0]      ptr_q;
  logic                   unused_fill_wr;

  bmide_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  bmide_lane_dec #(
    .WIN_BYTES  (WIN_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .AW         (ADDR_W)
  ) u_lane (
    .acc_wr    (acc_wr),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .acc_wdata (acc_wdata),
    .win_flat  (win_flat),
    .wr_be     (wr_be),
    .wr_bytes  (wr_bytes),
    .acc_rdata (acc_rdata)
  );

  bmide_cmd_ctl u_cmd (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cmd_we     (wr_be[OFS_CMD]),
    .cmd_wbyte  (wr_bytes[8*OFS_CMD +: 8]),
    .xfer_done  (xfer_done),
    .cmd_q      (cmd_q),
    .dma_active (dma_active),
    .dma_start  (dma_start)
  );

  bmide_stat_reg u_stat (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .st_we       (wr_be[OFS_STAT]),
    .st_wbyte    (wr_bytes[8*OFS_STAT +: 8]),
    .dma_active  (dma_active),
    .xfer_err    (xfer_err),
    .chan_irq_in (chan_irq_in),
    .stat_byte   (stat_byte),
    .irq_pend    (irq_pend),
    .irq_out     (irq_out)
  );

  bmide_ptr_reg #(
    .PTR_BYTES (DATA_BYTES)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ptr_be     (wr_be[WIN_BYTES-1:DATA_BYTES]),
    .ptr_wbytes (wr_bytes[8*WIN_BYTES-1:8*DATA_BYTES]),
    .ptr_q      (ptr_q)
  );

  // window image: lower group holds control bytes, upper group the pointer
  always_comb begin
    for (int b = 0; b < DATA_BYTES; b++) begin
      win_flat[8*b +: 8] = FILL_BYTE;
    end
    win_flat[8*OFS_CMD  +: 8] = cmd_q;
    win_flat[8*OFS_STAT +: 8] = stat_byte;
    win_flat[8*DATA_BYTES +: DATA_W] = ptr_q;
  end

  // writes to the fill bytes have nowhere to go
  assign unused_fill_wr = ^{wr_be[OFS_FILL_A], wr_be[OFS_FILL_B],
                            wr_bytes[8*OFS_FILL_A +: 8], wr_bytes[8*OFS_FILL_B +: 8],
                            irq_pend};

  assign tbl_base = ptr_q;
  assign xfer_dir = cmd_q[CMD_DIR_BIT];

endmodule

// File: rtl/bmide_regfile_chk.sv
module bmide_regfile_chk (
  input logic clk,
  input logic rst_n,
  input logic dma_start,
  input logic dma_active,
  input logic xfer_done,
  input logic chan_irq_in,
  input logic irq_pend
);

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> !$past(dma_active)); // R6

  AST_START_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |-> dma_active); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_start |=> !dma_start); // R3

  AST_ACTIVE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_active) |-> dma_start); // R3

  AST_STOP_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && !xfer_done) |=> dma_active); // R5

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_active && xfer_done) |=> !dma_active); // R7

  AST_IRQ_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chan_irq_in) |=> irq_pend); // R9

endmodule

bind bmide_regfile bmide_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .dma_start   (dma_start),
  .dma_active  (dma_active),
  .xfer_done   (xfer_done),
  .chan_irq_in (chan_irq_in),
  .irq_pend    (irq_pend)
);

// File: tb/bmide_regfile_tb.sv
module bmide_regfile_tb_top;

  logic        clk;
  logic        rst_n;
  logic        acc_wr;
  logic [2:0]  acc_addr;
  logic [1:0]  acc_size;
  logic [31:0] acc_wdata;
  logic [31:0] acc_rdata;
  logic        xfer_done;
  logic        xfer_err;
  logic        chan_irq_in;
  logic        irq_out;
  logic [31:0] tbl_base;
  logic        dma_start;
  logic        dma_active;
  logic        xfer_dir;

  int checks = 0;
  int fails  = 0;
  int start_cnt = 0;

  bmide_regfile dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_wr      (acc_wr),
    .acc_addr    (acc_addr),
    .acc_size    (acc_size),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .xfer_done   (xfer_done),
    .xfer_err    (xfer_err),
    .chan_irq_in (chan_irq_in),
    .irq_out     (irq_out),
    .tbl_base    (tbl_base),
    .dma_start   (dma_start),
    .dma_active  (dma_active),
    .xfer_dir    (xfer_dir)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (dma_start === 1'b1) start_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_size = s; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0; acc_wdata = '0;
    #2;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] s, output logic [31:0] d);
    acc_addr = a; acc_size = s;
    #1;
    d = acc_rdata;
  endtask

  task automatic pulse_done();
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0;
    #2;
  endtask

  task automatic pulse_err();
    @(negedge clk); xfer_err = 1'b1;
    @(negedge clk); xfer_err = 1'b0;
    #2;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd0, 2'd2, d); chk("R1 low group", d, 32'hFF00FF00);
    rd(3'd4, 2'd2, d); chk("R1 pointer", d, 32'h0);
    chk("R1 active", {31'b0, dma_active}, 32'h0);
    chk("R1 start", {31'b0, dma_start}, 32'h0);
  endtask

  task automatic t_cmd_mask();
    logic [31:0] d;
    int c0 = start_cnt;
    wr(3'd0, 2'd0, 32'hF6);
    rd(3'd0, 2'd0, d); chk("R2 masked F6", d, 32'h00);
    wr(3'd0, 2'd0, 32'hFE);
    rd(3'd0, 2'd0, d); chk("R2 masked FE", d, 32'h08);
    chk("R2 dir out", {31'b0, xfer_dir}, 32'h1);
    wr(3'd0, 2'd0, 32'h00);
    chk("R2 no start", start_cnt - c0, 0);
  endtask

  task automatic t_start();
    logic [31:0] d;
    int c0;
    wr(3'd4, 2'd2, 32'h1234567B);
    c0 = start_cnt;
    wr(3'd0, 2'd0, 32'h01);
    chk("R3 one pulse", start_cnt - c0, 1);
    chk("R3 active", {31'b0, dma_active}, 32'h1);
    rd(3'd2, 2'd0, d); chk("R3 status act", d, 32'h01);
    chk("R3 base", tbl_base, 32'h12345678);
    repeat (3) @(negedge clk);
    chk("R3 single pulse", start_cnt - c0, 1);
    pulse_done();
    chk("R7 done clears", {31'b0, dma_active}, 32'h0);
  endtask

  task automatic t_same_start();
    logic [31:0] d;
    int c0 = start_cnt;
    wr(3'd0, 2'd0, 32'h09);
    chk("R4 no pulse", start_cnt - c0, 0);
    chk("R4 active kept", {31'b0, dma_active}, 32'h0);
    rd(3'd0, 2'd0, d); chk("R4 stored", d, 32'h09);
  endtask

  task automatic t_stop_restart();
    int c0;
    wr(3'd0, 2'd0, 32'h00);
    c0 = start_cnt;
    wr(3'd0, 2'd0, 32'h01);
    chk("R3 restart pulse", start_cnt - c0, 1);
    wr(3'd0, 2'd0, 32'h00);
    repeat (4) @(negedge clk);
    chk("R5 stop keeps active", {31'b0, dma_active}, 32'h1);
    c0 = start_cnt;
    wr(3'd0, 2'd0, 32'h01);
    chk("R6 no pulse while active", start_cnt - c0, 0);
    chk("R6 still active", {31'b0, dma_active}, 32'h1);
    pulse_done();
    chk("R7 cleared", {31'b0, dma_active}, 32'h0);
    wr(3'd0, 2'd0, 32'h00);
  endtask

  task automatic t_status();
    logic [31:0] d;
    pulse_err();
    rd(3'd2, 2'd0, d); chk("R7 err set", d, 32'h02);
    wr(3'd2, 2'd0, 32'h60);
    rd(3'd2, 2'd0, d); chk("R8 rw set err kept", d, 32'h62);
    wr(3'd2, 2'd0, 32'hFF);
    rd(3'd2, 2'd0, d); chk("R8 w1c and rw", d, 32'h60);
    wr(3'd2, 2'd0, 32'h00);
    rd(3'd2, 2'd0, d); chk("R8 rw cleared", d, 32'h00);
    wr(3'd0, 2'd0, 32'h01);
    wr(3'd2, 2'd0, 32'h00);
    rd(3'd2, 2'd0, d); chk("R8 active read-only", d, 32'h01);
    pulse_done();
    wr(3'd0, 2'd0, 32'h00);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    @(negedge clk); chan_irq_in = 1'b1; #1;
    chk("R10 pass high", {31'b0, irq_out}, 32'h1);
    repeat (2) @(negedge clk); #1;
    rd(3'd2, 2'd0, d); chk("R9 pend set", d, 32'h04);
    @(negedge clk); chan_irq_in = 1'b0; #1;
    chk("R10 pass low", {31'b0, irq_out}, 32'h0);
    repeat (2) @(negedge clk); #1;
    rd(3'd2, 2'd0, d); chk("R10 fall no change", d, 32'h04);
    wr(3'd2, 2'd0, 32'h04);
    rd(3'd2, 2'd0, d); chk("R9 w1c", d, 32'h00);
    @(negedge clk);
    chan_irq_in = 1'b1;
    acc_wr = 1'b1; acc_addr = 3'd2; acc_size = 2'd0; acc_wdata = 32'h04;
    @(negedge clk);
    acc_wr = 1'b0; acc_wdata = '0;
    #2;
    rd(3'd2, 2'd0, d); chk("R9 set wins", d, 32'h04);
    @(negedge clk); chan_irq_in = 1'b0;
    wr(3'd2, 2'd0, 32'h04);
  endtask

  task automatic t_ptr();
    logic [31:0] d;
    wr(3'd4, 2'd2, 32'hFFFFFFFF);
    chk("R11 word align", tbl_base, 32'hFFFFFFFC);
    wr(3'd5, 2'd0, 32'h00);
    chk("R11 byte 5", tbl_base, 32'hFFFF00FC);
    wr(3'd6, 2'd1, 32'h1234);
    chk("R11 half 6", tbl_base, 32'h123400FC);
    wr(3'd4, 2'd0, 32'h03);
    chk("R11 byte 4 align", tbl_base, 32'h12340000);
    rd(3'd5, 2'd1, d); chk("R13 half read", d, 32'h00003400);
    wr(3'd4, 2'd1, 32'hABCF);
    chk("R11 half 4 align", tbl_base, 32'h1234ABCC);
    rd(3'd4, 2'd2, d); chk("R11 read back", d, 32'h1234ABCC);
    wr(3'd6, 2'd2, 32'hAABBCCDD);
    chk("R13 group cut", tbl_base, 32'hCCDDABCC);
    rd(3'd7, 2'd1, d); chk("R13 read cut", d, 32'h000000CC);
  endtask

  task automatic t_fill();
    logic [31:0] d;
    wr(3'd1, 2'd0, 32'h00);
    wr(3'd3, 2'd0, 32'h00);
    rd(3'd1, 2'd0, d); chk("R12 off1", d, 32'hFF);
    rd(3'd3, 2'd0, d); chk("R12 off3", d, 32'hFF);
    rd(3'd0, 2'd2, d); chk("R12 no side effect", d, 32'hFF00FF00);
    chk("R12 ptr untouched", tbl_base, 32'hCCDDABCC);
  endtask

  initial begin
    rst_n = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_size = '0; acc_wdata = '0;
    xfer_done = 1'b0; xfer_err = 1'b0; chan_irq_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    t_cmd_mask();
    t_start();
    t_same_start();
    t_stop_restart();
    t_status();
    t_irq();
    t_ptr();
    t_fill();
    finish_run();
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    finish_run();
  end

endmodule